// File: doc/BRIEF.md
# Latch-Framed Serial Register Port

This block is the serial slave side of a chip control port. After reset it stays passive, because the pins are shared with another control protocol. It becomes a four-wire serial slave once the host has pulsed the frame latch line low three times. From then on, every period with the latch low is one transaction. The transaction starts with a command byte, then a 16-bit target address, then data bytes. Data bytes are written to the register space or read back from it, and the address advances word by word through a burst.

The address decides how wide a word is. Addresses below a memory boundary (512 by default) hold 28-bit memory words, each moved as four bytes. The remaining addresses are byte-wide control registers. Toward the register file the block presents a plain parallel bus: one write strobe per completed word, and one read strobe per word to fetch. Read data is expected one clock after the read strobe. All serial pins are synchronised into the system clock and sampled there. For this reason the serial clock must run well below the system clock.

Top module: `spi_ctrl_port`

## Requirements
- R1: After reset `spi_mode_o` is 0. It becomes 1 after the third rising edge of `latch_ni` following reset, and stays 1 until the next reset.
- R2: While `spi_mode_o` is 0, no traffic on the serial pins produces a bus write strobe or a bus read strobe, and `sdo_oe_o` stays 0.
- R3: `sdi_i` is sampled on rising edges of `sclk_i`, MSB first. In the first byte, bit 0 selects the direction (1 read, 0 write) and bits 7:1 are a chip address that has no effect. The second and third bytes give the 16-bit start address, high byte first.
- R4: At an address at or above the memory boundary, each data byte of a write is one word. It produces a single-cycle `bus_we_o` with `bus_addr_o` equal to that address and `bus_wdata_o` equal to the byte, zero-extended.
- R5: At an address below the memory boundary, a word is four bytes. The upper 4 bits of the first byte are dropped, and `bus_wdata_o` carries the remaining 28 bits in bits 27:0 with bits 31:28 zero.
- R6: In a burst, the address increases by one after each completed word. Exactly one write strobe is issued per completed word. A burst may cross the boundary, and each word's width follows its own address.
- R7: In a read, `sdo_oe_o` is 0 during the three command bytes and 1 during data bytes. `sdo_o` changes on falling edges of `sclk_i`, MSB first. A register word returns `bus_rdata_i[7:0]`. A memory word returns four zero bits followed by `bus_rdata_i[27:0]`. A read issues no write strobe.
- R8: If `latch_ni` rises in the middle of a byte or of a memory word, the unfinished word is not written. Words already completed are still written. The next transaction starts again at the command byte.
- R9: While `latch_ni` is high, `sdo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| latch_ni | input | 1 | Frame latch, low during a transaction |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Drive enable for the serial read data pad |
| spi_mode_o | output | 1 | Serial slave mode has been entered |
| bus_addr_o | output | 16 | Register bus address |
| bus_wdata_o | output | 32 | Register bus write data |
| bus_we_o | output | 1 | Register bus write strobe, one cycle per word |
| bus_re_o | output | 1 | Register bus read strobe, data expected one cycle later |
| bus_rdata_i | input | 32 | Register bus read data |

## Verification
The write path is tried with register bursts of one to four bytes from several start addresses and with varied chip-address bits. These runs separate a correct per-word address step from an off-by-one and show that the chip address is ignored. Memory bursts carry a nonzero top nibble in their first byte, which exposes a missing nibble drop. A burst starting at the last memory address shows whether word width is decided per address. Frames are cut in the middle of a command byte, in the middle of a data byte and in the middle of a memory word, and each is followed by a clean write that shows the frame state was cleared. Reads use an address-derived pattern, so data from a wrong address, a wrong bit order or a wrong edge shows up as a mismatch, and the enable is observed over command bytes and data bytes separately.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_CHIP,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA
  } phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_mode_detect.sv
module spi_mode_detect #(
  parameter int PULSES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_rise_i,
  output logic mode_o
);

  localparam int CNT_W = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (!mode_q && latch_rise_i) begin
      if (cnt_q == CNT_LAST) mode_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign mode_o = mode_q;

  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> mode_q); // R1

  AST_MODE_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past(latch_rise_i)); // R1

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 512,
  parameter int MEM_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o,
  output logic              sdo_o,
  output logic              oe_o
);

  localparam int TX_W     = MEM_BYTES * BYTE_W;
  localparam int MEM_BITS = TX_W - 4;
  localparam int BC_W     = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;
  localparam int ACC_W    = (MEM_BYTES - 1) * BYTE_W;
  localparam logic [BC_W-1:0]   MEM_LAST = BC_W'(MEM_BYTES - 1);
  localparam logic [ADDR_W-1:0] MEM_END  = ADDR_W'(MEM_WORDS);

  phase_e            phase_q;
  logic [2:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ACC_W-1:0]  wacc_q;
  logic [BC_W-1:0]   wbyte_q;
  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sdo_q, oe_q, we_q, re_q, load_q, word_done_q;

  logic [BYTE_W-1:0] byte_next;
  logic [TX_W-1:0]   acc_next;
  logic              is_mem, byte_done, word_end;
  logic [BC_W-1:0]   last_byte;

  assign byte_next = {shift_q[BYTE_W-2:0], sdi_i};
  assign acc_next  = {wacc_q, byte_next};
  assign is_mem    = addr_q < MEM_END;
  assign last_byte = is_mem ? MEM_LAST : '0;
  assign byte_done = active_i && rise_i && (bit_cnt_q == 3'd7);
  assign word_end  = byte_done && (phase_q == PH_DATA) && (wbyte_q == last_byte);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_CHIP;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      rd_q        <= 1'b0;
      addr_q      <= '0;
      wacc_q      <= '0;
      wbyte_q     <= '0;
      tx_q        <= '0;
      wdata_q     <= '0;
      sdo_q       <= 1'b0;
      oe_q        <= 1'b0;
      we_q        <= 1'b0;
      re_q        <= 1'b0;
      load_q      <= 1'b0;
      word_done_q <= 1'b0;
    end else begin
      we_q        <= 1'b0;
      re_q        <= 1'b0;
      word_done_q <= 1'b0;
      load_q      <= re_q;
      if (!active_i) begin
        phase_q   <= PH_CHIP;
        bit_cnt_q <= '0;
        wbyte_q   <= '0;
        rd_q      <= 1'b0;
        oe_q      <= 1'b0;
      end else begin
        if (rise_i) begin
          shift_q   <= byte_next;
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (byte_done) begin
            unique case (phase_q)
              PH_CHIP: begin
                rd_q    <= byte_next[0];
                phase_q <= PH_ADDR_HI;
              end
              PH_ADDR_HI: begin
                addr_q  <= {addr_q[ADDR_W-BYTE_W-1:0], byte_next};
                phase_q <= PH_ADDR_LO;
              end
              PH_ADDR_LO: begin
                addr_q  <= {addr_q[ADDR_W-BYTE_W-1:0], byte_next};
                phase_q <= PH_DATA;
                wbyte_q <= '0;
                re_q    <= rd_q;
              end
              default: begin
                wacc_q <= acc_next[ACC_W-1:0];
                if (word_end) begin
                  wbyte_q     <= '0;
                  word_done_q <= 1'b1;
                  we_q        <= !rd_q;
                  wdata_q     <= is_mem ? DATA_W'(acc_next[MEM_BITS-1:0])
                                        : DATA_W'(byte_next);
                end else begin
                  wbyte_q <= wbyte_q + 1'b1;
                end
              end
            endcase
          end
        end
        // read data moves on the serial clock's falling edge
        if (fall_i && rd_q && phase_q == PH_DATA) begin
          sdo_q <= tx_q[TX_W-1];
          tx_q  <= tx_q << 1;
          oe_q  <= 1'b1;
        end
      end
      if (word_done_q) begin
        addr_q <= addr_q + 1'b1;
        re_q   <= rd_q;
      end
      if (load_q) begin
        tx_q <= is_mem ? TX_W'(rdata_i[MEM_BITS-1:0])
                       : {rdata_i[BYTE_W-1:0], {(TX_W-BYTE_W){1'b0}}};
      end
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
  assign re_o    = re_q;
  assign sdo_o   = sdo_q;
  assign oe_o    = oe_q;

  AST_OE_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> rd_q); // R7

  AST_WE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> !rd_q); // R7

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done_q |=> addr_q == $past(addr_q) + 1'b1); // R6

  AST_MEM_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && is_mem) |-> wdata_q[DATA_W-1:MEM_BITS] == '0); // R5

  AST_OE_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !oe_q); // R9

endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
  import spi_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int MEM_WORDS    = 512,
  parameter int MEM_BYTES    = 4,
  parameter int ENTRY_PULSES = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              spi_mode_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);

  logic [2:0] pins_s;
  logic       latch_s, sclk_s, sdi_s;
  logic       latch_d_q, sclk_d_q;
  logic       latch_rise, sclk_rise, sclk_fall;
  logic       mode, active;

  spi_pin_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({latch_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  assign latch_s = pins_s[2];
  assign sclk_s  = pins_s[1];
  assign sdi_s   = pins_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_d_q <= 1'b1;
      sclk_d_q  <= 1'b0;
    end else begin
      latch_d_q <= latch_s;
      sclk_d_q  <= sclk_s;
    end
  end

  assign latch_rise = latch_s & ~latch_d_q;
  assign sclk_rise  = sclk_s & ~sclk_d_q;
  assign sclk_fall  = ~sclk_s & sclk_d_q;

  spi_mode_detect #(.PULSES(ENTRY_PULSES)) i_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_rise_i(latch_rise),
    .mode_o      (mode)
  );

  assign active = mode & ~latch_s;

  spi_frame_engine #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MEM_WORDS(MEM_WORDS),
    .MEM_BYTES(MEM_BYTES)
  ) i_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .rise_i  (sclk_rise),
    .fall_i  (sclk_fall),
    .sdi_i   (sdi_s),
    .rdata_i (bus_rdata_i),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o),
    .we_o    (bus_we_o),
    .re_o    (bus_re_o),
    .sdo_o   (sdo_o),
    .oe_o    (sdo_oe_o)
  );

  assign spi_mode_o = mode;

  AST_QUIET_BEFORE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |-> !(bus_we_o || bus_re_o || sdo_oe_o)); // R2

endmodule

// File: tb/test_spi_ctrl_port.sv
module test_spi_ctrl_port;

  localparam int HP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        latch_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe, spi_mode, bus_we, bus_re;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  always #2 clk = ~clk;

  spi_ctrl_port i_spi_ctrl_port (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .latch_ni   (latch_n),
    .sclk_i     (sclk),
    .sdi_i      (sdi),
    .sdo_o      (sdo),
    .sdo_oe_o   (sdo_oe),
    .spi_mode_o (spi_mode),
    .bus_addr_o (bus_addr),
    .bus_wdata_o(bus_wdata),
    .bus_we_o   (bus_we),
    .bus_re_o   (bus_re),
    .bus_rdata_i(bus_rdata)
  );

  function automatic logic [31:0] pat(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic logic [7:0] wbyte(input logic [15:0] st, input int i);
    return 8'(st[7:0] * 7 + i * 13 + 1);
  endfunction

  // register file model: read data one cycle after the strobe
  int          wr_cnt = 0;
  int          re_cnt = 0;
  logic [15:0] wr_a [64];
  logic [31:0] wr_d [64];

  always @(posedge clk) begin
    if (bus_re) begin
      bus_rdata <= pat(bus_addr);
      re_cnt    <= re_cnt + 1;
    end
    if (bus_we) begin
      if (wr_cnt < 64) begin
        wr_a[wr_cnt] <= bus_addr;
        wr_d[wr_cnt] <= bus_wdata;
      end
      wr_cnt <= wr_cnt + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  logic [7:0]  txb [16];
  logic [7:0]  rxb [16];
  logic        oe_cmd_any, oe_data_all;
  logic [15:0] st;
  logic [31:0] word, expv;
  int          base;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [6:0] chip, input logic rd, input logic [15:0] a);
    txb[0] = {chip, rd};
    txb[1] = a[15:8];
    txb[2] = a[7:0];
  endtask

  task automatic run(input int nbits);
    logic r, o;
    latch_n     = 1'b0;
    oe_cmd_any  = 1'b0;
    oe_data_all = 1'b1;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = txb[i/8][7 - (i % 8)];
      repeat (HP) @(negedge clk);
      r = sdo;
      o = sdo_oe;
      sclk = 1'b1;
      rxb[i/8] = {rxb[i/8][6:0], r};
      if (i < 24) oe_cmd_any = oe_cmd_any | o;
      else        oe_data_all = oe_data_all & o;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    latch_n = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic pulse();
    latch_n = 1'b0;
    repeat (HP) @(negedge clk);
    latch_n = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) txb[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R1 mode after reset", 32'(spi_mode), 32'd0);
    chk("R9 oe after reset", 32'(sdo_oe), 32'd0);
    chk("R2 strobes after reset", 32'({bus_we, bus_re}), 32'd0);

    // traffic before mode entry is ignored (counts as pulse 1)
    cmd(7'h34, 1'b0, 16'h4010); txb[3] = 8'h11;
    run(32);
    chk("R2 no write before mode", 32'(wr_cnt), 32'd0);
    cmd(7'h34, 1'b1, 16'h4010);
    run(40);
    chk("R2 no read before mode", 32'(re_cnt), 32'd0);
    chk("R2 no oe before mode", 32'(oe_data_all & oe_cmd_any), 32'd0);
    chk("R1 mode after two pulses", 32'(spi_mode), 32'd0);
    pulse();
    chk("R1 mode after third pulse", 32'(spi_mode), 32'd1);

    // single register write
    base = wr_cnt;
    cmd(7'h00, 1'b0, 16'h4015); txb[3] = 8'h5A;
    run(32);
    chk("R4 write count", 32'(wr_cnt - base), 32'd1);
    chk("R4 write addr", 32'(wr_a[base]), 32'h4015);
    chk("R4 write data", wr_d[base], 32'h5A);

    // register burst sweep with varied chip address bits
    for (int len = 1; len <= 4; len++) begin
      for (int k = 0; k < 3; k++) begin
        st = 16'h4000 + 16'(len * 16 + k * 5);
        base = wr_cnt;
        cmd(7'(len * 29 + k * 41), 1'b0, st);
        for (int i = 0; i < len; i++) txb[3+i] = wbyte(st, i);
        run(24 + 8 * len);
        chk("R6 burst count / R3 chip ignored", 32'(wr_cnt - base), 32'(len));
        for (int i = 0; i < len; i++) begin
          chk("R6 burst addr", 32'(wr_a[base+i]), 32'(st + 16'(i)));
          chk("R4 burst data", wr_d[base+i], 32'(wbyte(st, i)));
        end
      end
    end

    // memory words, top nibble of first byte dropped
    for (int k = 0; k < 3; k++) begin
      st = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0010 : 16'h01FE;
      base = wr_cnt;
      cmd(7'h11, 1'b0, st);
      for (int j = 0; j < 2; j++) begin
        word = 32'hF000_0000 | (32'(j + k) * 32'h0135_7911 + 32'h00AB_CDEF);
        for (int b = 0; b < 4; b++) txb[3 + 4*j + b] = word[31 - 8*b -: 8];
      end
      run(24 + 64);
      chk("R5 mem word count", 32'(wr_cnt - base), 32'd2);
      for (int j = 0; j < 2; j++) begin
        word = 32'hF000_0000 | (32'(j + k) * 32'h0135_7911 + 32'h00AB_CDEF);
        chk("R6 mem addr", 32'(wr_a[base+j]), 32'(st + 16'(j)));
        chk("R5 mem data", wr_d[base+j], {4'h0, word[27:0]});
      end
    end

    // burst crossing from memory into registers
    base = wr_cnt;
    cmd(7'h02, 1'b0, 16'h01FF);
    txb[3] = 8'hAB; txb[4] = 8'hCD; txb[5] = 8'hEF; txb[6] = 8'h01;
    txb[7] = 8'h96; txb[8] = 8'h69;
    run(24 + 48);
    chk("R6 cross count", 32'(wr_cnt - base), 32'd3);
    chk("R5 cross mem data", wr_d[base], 32'h0BCDEF01);
    chk("R6 cross reg addr", 32'(wr_a[base+1]), 32'h0200);
    chk("R4 cross reg data", wr_d[base+1], 32'h96);
    chk("R6 cross reg addr 2", 32'(wr_a[base+2]), 32'h0201);
    chk("R4 cross reg data 2", wr_d[base+2], 32'h69);

    // aborted frames
    base = wr_cnt;
    cmd(7'h00, 1'b0, 16'h4020); txb[3] = 8'h77; txb[4] = 8'hFF;
    run(24 + 8 + 5);
    chk("R8 mid-byte keeps done word only", 32'(wr_cnt - base), 32'd1);
    chk("R8 done word data", wr_d[base], 32'h77);
    base = wr_cnt;
    cmd(7'h00, 1'b0, 16'h0020); txb[3] = 8'h12; txb[4] = 8'h34;
    run(24 + 16);
    chk("R8 partial mem word dropped", 32'(wr_cnt - base), 32'd0);
    cmd(7'h00, 1'b0, 16'h4444);
    run(13);
    chk("R8 mid-command no write", 32'(wr_cnt - base), 32'd0);
    cmd(7'h00, 1'b0, 16'h4030); txb[3] = 8'hC3;
    run(32);
    chk("R8 fresh frame count", 32'(wr_cnt - base), 32'd1);
    chk("R8 fresh frame addr", 32'(wr_a[base]), 32'h4030);
    chk("R8 fresh frame data", wr_d[base], 32'hC3);

    // register reads
    for (int k = 0; k < 3; k++) begin
      st = 16'h4008 + 16'(k * 37);
      base = wr_cnt;
      cmd(7'(k * 50), 1'b1, st);
      for (int i = 3; i < 16; i++) txb[i] = 8'h00;
      run(24 + 24);
      chk("R7 oe low in command", 32'(oe_cmd_any), 32'd0);
      chk("R7 oe high in data", 32'(oe_data_all), 32'd1);
      for (int i = 0; i < 3; i++)
        chk("R7 reg read data", 32'(rxb[3+i]), 32'(pat(st + 16'(i)) & 32'hFF));
      chk("R7 read no write", 32'(wr_cnt - base), 32'd0);
      chk("R9 oe after frame", 32'(sdo_oe), 32'd0);
    end

    // memory reads, including the crossing into registers
    st = 16'h0005;
    cmd(7'h7F, 1'b1, st);
    run(24 + 64);
    for (int j = 0; j < 2; j++) begin
      word = {rxb[3+4*j], rxb[4+4*j], rxb[5+4*j], rxb[6+4*j]};
      expv = pat(st + 16'(j));
      chk("R7 mem read data", word, {4'h0, expv[27:0]});
    end
    st = 16'h01FF;
    cmd(7'h01, 1'b1, st);
    run(24 + 40);
    word = {rxb[3], rxb[4], rxb[5], rxb[6]};
    expv = pat(16'h01FF);
    chk("R7 cross mem read", word, {4'h0, expv[27:0]});
    chk("R7 cross reg read", 32'(rxb[7]), pat(16'h0200) & 32'hFF);
    chk("R7 cross oe", 32'({oe_cmd_any, oe_data_all}), 32'd1);
    chk("R9 oe idle", 32'(sdo_oe), 32'd0);
    chk("R1 mode held", 32'(spi_mode), 32'd1);

    finish_run();
  end

endmodule